// File: doc/BRIEF.md
# Shared-Enable I/O Register Pair

This block is a register cell that sits beside a pad. It holds two registers that share one clock and one clock-enable pin. The capture register samples the value coming in from the pad and presents it to the core. The launch register samples the value the core wants to send and presents it to the pad. Both registers are the same width.

Two static selection bits decide, for each register separately, whether the shared enable governs it. A register that is governed by the enable keeps its value on an active edge where the enable is low. A register that is not governed loads on every active edge. A third static bit picks whether the active edge is the rising or the falling edge of the clock. The enable acts as a synchronous hold through a data-path multiplexer, and the clock is never gated. The configuration is taken in on rising clock edges while reset is high, and is then frozen until the next reset.

The data paths are plain register stages with no valid/ready handshake. The cell never stalls and never applies back-pressure. The shared enable is the only means of holding a value. An asynchronous active-high reset clears both registers.

Top module: `iocell_pair`

## Requirements
- R1: While `rst_i` is high, both `core_q_o` and `pad_q_o` are 0. The clear takes effect at once, without waiting for a clock edge, and whatever level `ce_i` has.
- R2: When `cfg_ce_sel_i[0]` was 1 at reset, `core_q_o` takes the value of `pad_din_i` only on active edges where `ce_i` is 1. On active edges where `ce_i` is 0 it keeps its value.
- R3: When `cfg_ce_sel_i[1]` was 1 at reset, `pad_q_o` takes the value of `core_dout_i` only on active edges where `ce_i` is 1. On active edges where `ce_i` is 0 it keeps its value.
- R4: A register whose selection bit was 0 at reset loads its data input on every active edge, whatever level `ce_i` has.
- R5: When `cfg_fall_i` was 0 at reset, the active edge is the rising clock edge. When it was 1, the active edge is the falling clock edge.
- R6: The configuration pins are sampled on rising `clk_i` edges while `rst_i` is high. Changes to them while `rst_i` is low have no effect on either register.
- R7: The two paths are independent. `core_q_o` depends only on `pad_din_i`, and `pad_q_o` depends only on `core_dout_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Cell clock |
| rst_i | input | 1 | Asynchronous active-high reset; also opens the configuration sampling window |
| cfg_ce_sel_i | input | 2 | Bit 0: the enable governs the capture register. Bit 1: the enable governs the launch register |
| cfg_fall_i | input | 1 | 0: rising active edge. 1: falling active edge |
| ce_i | input | 1 | Shared clock enable |
| pad_din_i | input | WIDTH | Data arriving from the pad |
| core_dout_i | input | WIDTH | Data from the core to be sent to the pad |
| core_q_o | output | WIDTH | Registered pad data toward the core |
| pad_q_o | output | WIDTH | Registered core data toward the pad |

## Verification
The bench runs every combination of the two selection bits with both edge polarities. In each of these eight setups it drives pseudo-random data on both paths and a shared enable that toggles irregularly. Runs where only one register is governed show that the enable is routed per register and not shared blindly. Runs where neither register is governed show that loading ignores the enable. Comparing the rising-edge setups with the falling-edge setups, with inputs held stable across the inactive edge, shows which edge loads the registers. Halfway through each setup the configuration pins are driven to their complement, and the expected values keep following the configuration taken at reset.

// File: rtl/iocell_pkg.sv
package iocell_pkg;
  localparam int NUM_PATHS = 2;
  localparam int PATH_IN   = 0;
  localparam int PATH_OUT  = 1;

  typedef struct packed {
    logic [NUM_PATHS-1:0] ce_sel;
    logic                 fall;
  } iocell_cfg_t;
endpackage

// File: rtl/iocell_cfg.sv
module iocell_cfg
  import iocell_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  iocell_cfg_t cfg_i,
  output iocell_cfg_t cfg_o
);
  iocell_cfg_t cfg_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;

  // R6
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> $stable(cfg_q));
endmodule

// File: rtl/iocell_edge.sv
module iocell_edge (
  input  logic clk_i,
  input  logic fall_i,
  output logic clk_o
);
  assign clk_o = clk_i ^ fall_i;
endmodule

// File: rtl/iocell_flop.sv
module iocell_flop #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             gate_i,
  input  logic             ce_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic             load;
  logic [WIDTH-1:0] q_r;

  assign load = !gate_i || ce_i;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)     q_r <= '0;
    else if (load) q_r <= d_i;
  end

  assign q_o = q_r;

  // R2 R3
  hold_when_gated_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (gate_i && !ce_i) |=> $stable(q_o));

  // R4
  load_when_open_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!gate_i || ce_i) |=> (q_o == $past(d_i)));
endmodule

// File: rtl/iocell_pair.sv
module iocell_pair
  import iocell_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [1:0]       cfg_ce_sel_i,
  input  logic             cfg_fall_i,
  input  logic             ce_i,
  input  logic [WIDTH-1:0] pad_din_i,
  input  logic [WIDTH-1:0] core_dout_i,
  output logic [WIDTH-1:0] core_q_o,
  output logic [WIDTH-1:0] pad_q_o
);
  iocell_cfg_t      cfg_in;
  iocell_cfg_t      cfg_q;
  logic             act_clk;
  logic [WIDTH-1:0] d_arr [NUM_PATHS];
  logic [WIDTH-1:0] q_arr [NUM_PATHS];

  assign cfg_in.ce_sel = cfg_ce_sel_i;
  assign cfg_in.fall   = cfg_fall_i;

  iocell_cfg u_cfg (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .cfg_i (cfg_in),
    .cfg_o (cfg_q)
  );

  iocell_edge u_edge (
    .clk_i  (clk_i),
    .fall_i (cfg_q.fall),
    .clk_o  (act_clk)
  );

  assign d_arr[PATH_IN]  = pad_din_i;
  assign d_arr[PATH_OUT] = core_dout_i;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    iocell_flop #(.WIDTH(WIDTH)) u_flop (
      .clk_i  (act_clk),
      .rst_i  (rst_i),
      .gate_i (cfg_q.ce_sel[p]),
      .ce_i   (ce_i),
      .d_i    (d_arr[p]),
      .q_o    (q_arr[p])
    );
  end

  assign core_q_o = q_arr[PATH_IN];
  assign pad_q_o  = q_arr[PATH_OUT];

  // R1
  core_reset_clear_chk: assert property (@(posedge clk_i)
    rst_i |-> (core_q_o == '0));

  // R1
  pad_reset_clear_chk: assert property (@(posedge clk_i)
    rst_i |-> (pad_q_o == '0));
endmodule

// File: tb/test_iocell_pair.sv
module test_iocell_pair;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   sel = 2'b00;
  logic         fall = 1'b0;
  logic         ce = 1'b0;
  logic [W-1:0] pad_d = '0;
  logic [W-1:0] core_d = '0;
  logic [W-1:0] core_q;
  logic [W-1:0] pad_q;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [W-1:0] exp_core, exp_pad;

  iocell_pair #(.WIDTH(W)) i_iocell_pair (
    .clk_i        (clk),
    .rst_i        (rst),
    .cfg_ce_sel_i (sel),
    .cfg_fall_i   (fall),
    .ce_i         (ce),
    .pad_din_i    (pad_d),
    .core_dout_i  (core_d),
    .core_q_o     (core_q),
    .pad_q_o      (pad_q)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic run_cfg(input logic [1:0] s, input logic f);
    // Asynchronous clear, checked before any clock edge
    @(posedge clk); #2;
    ce = 1'b0;
    rst = 1'b1;
    #1;
    check("R1 async core", core_q, '0);
    check("R1 async pad", pad_q, '0);
    sel = s; fall = f;
    pad_d = 4'hF; core_d = 4'hF; ce = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    check("R1 held core", core_q, '0);
    check("R1 held pad", pad_q, '0);
    exp_core = '0; exp_pad = '0;
    rst = 1'b0;
    lfsr = step(lfsr);
    pad_d = lfsr[3:0]; core_d = lfsr[7:4]; ce = lfsr[8];
    for (int c = 0; c < 40; c++) begin
      if (f) @(negedge clk); else @(posedge clk);
      // Model: R2/R3 gated by ce, R4 ungated; R5 edge per f
      if (!s[0] || ce) exp_core = pad_d;
      if (!s[1] || ce) exp_pad = core_d;
      #2;
      check(s[0] ? "R2 core gated" : "R4 core free", core_q, exp_core);
      check(s[1] ? "R3 pad gated" : "R4 pad free", pad_q, exp_pad);
      // R5: outputs stay stable across the inactive edge
      if (f) @(posedge clk); else @(negedge clk);
      #1;
      check("R5 inactive edge core", core_q, exp_core);
      check("R5 inactive edge pad", pad_q, exp_pad);
      // R6: scramble configuration pins after reset
      if (c == 20) begin sel = ~s; fall = ~f; end
      lfsr = step(lfsr);
      // R7: each path gets its own independent data
      pad_d = lfsr[3:0]; core_d = lfsr[11:8];
      ce = (c % 7 < 3) ? 1'b1 : lfsr[5];
    end
  endtask

  initial begin : watchdog
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    check("R1 reset core", core_q, '0);
    check("R1 reset pad", pad_q, '0);
    for (int m = 0; m < 8; m++) begin
      run_cfg(m[1:0], m[2]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule